// File: doc/BRIEF.md
# Registered Rounding Parallel Multiplier

This block multiplies two 8-bit operands and holds the 16-bit result in a register. Each operand has its own input register, and so does the result. Each of the three registers is a clock enable on one rising-edge system clock, and each loads only when its own load strobe is high. The result register captures the combinational product of the two operand registers, so a value loaded into operand A on one edge reaches the result register on a later edge that has the result strobe high.

A parameter selects the arithmetic. In signed mode the operands and the result are two's complement. In unsigned mode they are plain magnitudes. A round request is captured alongside the operands. Its capture strobe depends on the mode. When the captured request is set, the result is biased so that keeping only the upper byte gives a correctly rounded 8-bit value. The result leaves the block as two bytes. Each byte has its own active-low output enable, so either byte can be released to high impedance on a shared bus.

Top module: `rnd_mult`

## Requirements
- R1: A synchronous active-high reset clears both operand registers, the captured round bit and the result register, so an enabled output reads 0x00 on both bytes afterwards.
- R2: Operand A loads only on a clock edge with `load_a` high, and operand B only on an edge with `load_b` high. The result register loads only on an edge with `load_r` high, from the operand registers as they were before that edge.
- R3: With SIGNED_MODE=1, let P be the 15-bit two's complement product. The upper byte is {sign, P[13:7]} and the lower byte is {sign, P[6:0]}.
- R4: With SIGNED_MODE=1, bit 7 of the upper byte always equals bit 7 of the lower byte.
- R5: With SIGNED_MODE=0, the result is the unsigned 16-bit product, with the upper byte as bits 15..8 and the lower byte as bits 7..0.
- R6: The round request is captured on any edge with `load_a` or `load_b` high when SIGNED_MODE=1, and only on edges with `load_a` high when SIGNED_MODE=0.
- R7: A captured round bit of 1 adds one unit at the top magnitude position of the lower byte before the result is captured. That unit is 64 of P in signed mode and 128 in unsigned mode. In unsigned mode any carry out of bit 15 is dropped.
- R8: In signed mode, a product or rounded sum above 16383 (only -128 times -128) saturates to 16383, which reads as upper 0x7F and lower 0x7F.
- R9: When `hi_oe_n` is high the upper byte output is high impedance, and when `lo_oe_n` is high the lower byte output is high impedance. Neither enable changes any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 8 | Operand A |
| b_in | input | 8 | Operand B |
| load_a | input | 1 | Load strobe for operand A |
| load_b | input | 1 | Load strobe for operand B |
| load_r | input | 1 | Load strobe for the result register |
| round_in | input | 1 | Round request |
| hi_oe_n | input | 1 | Active-low enable of the upper byte |
| lo_oe_n | input | 1 | Active-low enable of the lower byte |
| hi_out | output | 8 | Upper result byte, high impedance when disabled |
| lo_out | output | 8 | Lower result byte, high impedance when disabled |

## Verification
The hold assertions assume that the strobes and the reset are never X and change only away from the clock edge. The bench meets this by driving every input on the falling edge from known values. The saturation assertion relies on the operand registers holding the corner value when `load_r` rises. The bench therefore loads the corner operands one cycle before it strobes the result. Its random phase leaves the enables, strobes and round request independent of one another, so the strobes overlap with each other and with the high-impedance states.

// File: rtl/rnd_mult.sv
module rnd_mult #(
  parameter int W           = 8,
  parameter bit SIGNED_MODE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         load_a,
  input  logic         load_b,
  input  logic         load_r,
  input  logic         round_in,
  input  logic         hi_oe_n,
  input  logic         lo_oe_n,
  output logic [W-1:0] hi_out,
  output logic [W-1:0] lo_out
);
  localparam int PW = 2 * W;

  logic [W-1:0]  a_q, b_q;
  logic          rnd_q;
  logic [PW-1:0] res_q, res_d;

  wire rnd_load = SIGNED_MODE ? (load_a | load_b) : load_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      b_q   <= '0;
      rnd_q <= 1'b0;
      res_q <= '0;
    end else begin
      if (load_a)   a_q   <= a_in;
      if (load_b)   b_q   <= b_in;
      if (rnd_load) rnd_q <= round_in;
      if (load_r)   res_q <= res_d;
    end
  end

  generate
    if (SIGNED_MODE) begin : g_signed
      localparam int MAXI = (1 << (PW - 2)) - 1;
      logic signed [PW:0] prod, sum, clip;
      assign prod = $signed({{(W+1){a_q[W-1]}}, a_q}) * $signed({{(W+1){b_q[W-1]}}, b_q});
      assign sum  = prod + $signed({{(PW-W+2){1'b0}}, rnd_q, {(W-2){1'b0}}});
      assign clip = (sum > MAXI) ? (PW+1)'(MAXI) : sum;
      assign res_d = {clip[PW-2], clip[PW-3:W-1], clip[PW-2], clip[W-2:0]};

      AST_SIGN_REPLICA: assert property (@(posedge clk) disable iff (rst)
        res_q[PW-1] == res_q[W-1]); // R4
      AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (load_r && a_q == {1'b1, {(W-1){1'b0}}} && b_q == {1'b1, {(W-1){1'b0}}})
        |=> res_q == {1'b0, {(W-1){1'b1}}, 1'b0, {(W-1){1'b1}}}); // R8
    end else begin : g_unsigned
      logic [PW-1:0] prod;
      assign prod  = {{W{1'b0}}, a_q} * {{W{1'b0}}, b_q};
      assign res_d = prod + {{W{1'b0}}, rnd_q, {(W-1){1'b0}}};
    end
  endgenerate

  assign hi_out = hi_oe_n ? {W{1'bz}} : res_q[PW-1:W];
  assign lo_out = lo_oe_n ? {W{1'bz}} : res_q[W-1:0];

  AST_A_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_a |=> $stable(a_q)); // R2
  AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_b |=> $stable(b_q)); // R2
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_r |=> $stable(res_q)); // R2
  AST_RND_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(load_a || (SIGNED_MODE && load_b)) |=> $stable(rnd_q)); // R6
endmodule

// File: tb/rnd_mult_tb.sv
`timescale 1ns/1ps
module rnd_mult_tb;
  logic clk = 0, rst = 1;
  logic [7:0] a_in = 0, b_in = 0;
  logic load_a = 0, load_b = 0, load_r = 0, round_in = 0, hi_oe_n = 0, lo_oe_n = 0;
  logic [7:0] hs, ls, hu, lu;
  int errors = 0, checks = 0;
  string req = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  rnd_mult #(.W(8), .SIGNED_MODE(1'b1)) u_dut (.clk, .rst, .a_in, .b_in, .load_a, .load_b,
    .load_r, .round_in, .hi_oe_n, .lo_oe_n, .hi_out(hs), .lo_out(ls));
  rnd_mult #(.W(8), .SIGNED_MODE(1'b0)) u_dut_u (.clk, .rst, .a_in, .b_in, .load_a, .load_b,
    .load_r, .round_in, .hi_oe_n, .lo_oe_n, .hi_out(hu), .lo_out(lu));

  int ma, mb, mrs, mru;
  logic [15:0] exp_s, exp_u;

  function automatic logic [15:0] ref_s(int a, int b, int r);
    int p;
    logic [15:0] v;
    p = (a > 127 ? a - 256 : a) * (b > 127 ? b - 256 : b) + (r ? 64 : 0);
    if (p > 16383) p = 16383;
    v = p[15:0];
    return {v[14], v[13:7], v[14], v[6:0]};
  endfunction

  function automatic logic [15:0] ref_u(int a, int b, int r);
    int p;
    p = (a * b + (r ? 128 : 0)) % 65536;
    return p[15:0];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ma = 0; mb = 0; mrs = 0; mru = 0; exp_s = 0; exp_u = 0;
    end else begin
      if (load_r) begin
        exp_s = ref_s(ma, mb, mrs);
        exp_u = ref_u(ma, mb, mru);
      end
      if (load_a || load_b) mrs = round_in;
      if (load_a) begin mru = round_in; ma = a_in; end
      if (load_b) mb = b_in;
    end
  end

  task automatic cmp(string nm, logic [7:0] act, logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, nm, act, expv);
    end
  endtask

  task automatic check_all();
    cmp("signed hi", hs, hi_oe_n ? 8'hzz : exp_s[15:8]);
    cmp("signed lo", ls, lo_oe_n ? 8'hzz : exp_s[7:0]);
    cmp("unsigned hi", hu, hi_oe_n ? 8'hzz : exp_u[15:8]);
    cmp("unsigned lo", lu, lo_oe_n ? 8'hzz : exp_u[7:0]);
    if (!hi_oe_n && !lo_oe_n) begin
      checks++;
      if (hs[7] !== ls[7]) begin
        errors++;
        $display("FAIL R4 sign replica: actual=%b expected=%b", ls[7], hs[7]);
      end
    end
  endtask

  task automatic step(logic [7:0] a, logic [7:0] b, logic la, logic lb, logic lr,
                      logic rn, logic oh, logic ol);
    @(negedge clk);
    check_all();
    a_in = a; b_in = b; load_a = la; load_b = lb; load_r = lr;
    round_in = rn; hi_oe_n = oh; lo_oe_n = ol;
  endtask

  task automatic mul(logic [7:0] a, logic [7:0] b, logic rn);
    step(a, b, 1, 1, 0, rn, 0, 0);
    step(a, b, 0, 0, 1, 0, 0, 0);
    step(a, b, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 0;
    req = "R1";
    step(8'h11, 8'h22, 0, 0, 0, 0, 0, 0);
    step(8'h11, 8'h22, 0, 0, 0, 0, 0, 0);
    req = "R3";
    mul(8'h05, 8'hFD, 0); mul(8'h7F, 8'h7F, 0); mul(8'h80, 8'h7F, 0); mul(8'hFF, 8'hFF, 0);
    req = "R5";
    mul(8'hFF, 8'hFF, 0); mul(8'h00, 8'h93, 0); mul(8'h10, 8'h10, 0);
    req = "R8";
    mul(8'h80, 8'h80, 0); mul(8'h80, 8'h80, 1);
    req = "R7";
    mul(8'hFF, 8'hFF, 1); mul(8'h40, 8'h02, 1); mul(8'h01, 8'hBF, 1);
    req = "R6";
    step(8'h03, 8'h09, 1, 1, 0, 0, 0, 0);
    step(8'h03, 8'h47, 0, 1, 0, 1, 0, 0);
    step(8'h03, 8'h47, 0, 0, 1, 0, 0, 0);
    step(8'h03, 8'h47, 0, 0, 0, 0, 0, 0);
    req = "R2";
    step(8'h21, 8'h33, 1, 0, 1, 0, 0, 0);
    step(8'h99, 8'h33, 0, 0, 1, 0, 0, 0);
    step(8'h99, 8'h44, 0, 1, 0, 0, 0, 0);
    step(8'h99, 8'h44, 0, 0, 0, 0, 0, 0);
    req = "R9";
    step(8'h12, 8'h34, 1, 1, 0, 0, 1, 0);
    step(8'h12, 8'h34, 0, 0, 1, 0, 1, 1);
    step(8'h12, 8'h34, 0, 0, 0, 0, 0, 1);
    step(8'h12, 8'h34, 0, 0, 0, 0, 0, 0);
    req = "R3";
    for (int i = 0; i < 3000; i++)
      step($urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
           ($urandom % 4) == 0, ($urandom % 4) == 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule